// File: doc/BRIEF.md
# Configurable Pin Controller

This block controls one general-purpose pin of a test instrument. An internal peripheral, routed to the pin elsewhere, supplies an output level and an output enable. The block turns that request into the pad's tri-state controls (`pad_out`, `pad_oe`) according to a drive mode chosen by software. It also samples the pad input through a synchronizer and keeps a sticky activity flag that software reads and clears. Two control outputs select an external pull-up or pull-down.

Software reaches the pin through two byte registers at a base address that the instance parameters select. At offset 0 is the status register: bit 0 is the synchronized pad level and bit 1 is the activity flag. At offset 1 is the write-only setup register: bits [1:0] are the drive mode and bits [3:2] are the pull code. A digital pin with index n has its base at 0xE060 + 0x10·n. An analog-side pin with index n (0 to 3) has its base at 0xE000 + 0x10·n.

The activity flag is a small state machine with three states. WARMUP lasts from reset until the synchronizer holds real samples. QUIET means no activity has been seen since the last clear. LATCHED means activity was seen. The transitions are: WARMUP→QUIET once the warm-up count reaches the number of synchronizer stages. QUIET→LATCHED on a change of the synchronized level. LATCHED→QUIET on a clearing write that does not coincide with a change. In every other case the state stays where it is.

Top module: `iopin_ctl`

## Requirements
- R1: After reset, a read at offset 0 returns 0 in bit 1 (flag clear). Both pull outputs are 0. The drive mode is 0, so `pad_oe` is 0 whenever `periph_oe` is 0.
- R2: Bit 0 of offset 0 shows `pad_in` after a two-flop synchronizer. A change driven before clock edge k is visible after edge k+1 and not after edge k. Writing bit 0 has no effect on it.
- R3: Any change of the synchronized level sets bit 1 of offset 0. The flag is set one edge after the change becomes visible in bit 0. An input pulse that spans a single clock edge of a 200 MHz clock (more than 5 ns wide) is caught.
- R4: The flag stays set until a write to offset 0 with bit 1 = 0 clears it. A write with bit 1 = 1 leaves it set.
- R5: If a clearing write and a level change fall in the same cycle, the flag ends up set.
- R6: A pad that is high through reset does not set the flag while the synchronizer fills.
- R7: Mode 0 (auto) and mode 3 (reserved) pass `periph_out` and `periph_oe` straight to `pad_out` and `pad_oe`.
- R8: Mode 1 (open-drain) drives `pad_out` = 0 with `pad_oe` = 1 only while `periph_oe` = 1 and `periph_out` = 0. Otherwise it releases the pad (`pad_oe` = 0).
- R9: Mode 2 (push-only) drives `pad_out` = 1 with `pad_oe` = 1 only while `periph_oe` = 1 and `periph_out` = 1. Otherwise it releases the pad.
- R10: Setup bits [3:2] select the pull. Code 1 asserts `pull_dn_en`, code 3 asserts `pull_up_en`, and codes 0 and 2 assert neither. The two outputs are never high together.
- R11: The block decodes only its own base and base + 1. Writes to other addresses change nothing. Reads of base + 1 and of any other address return 0. Setup bits [7:4] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| periph_out | input | 1 | Output level requested by the routed peripheral |
| periph_oe | input | 1 | Output enable requested by the routed peripheral |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable (0 = high impedance) |
| pull_up_en | output | 1 | Enables the external pull-up |
| pull_dn_en | output | 1 | Enables the external pull-down |

## Verification
The hardest case to reach is R5. The clearing write must land in the one cycle when the synchronizer reports a change, and the flag must already be LATCHED so that the priority matters. The bench first latches the flag with one toggle of the pad. It then toggles the pad again at a falling edge, counts two rising edges, and raises the clearing write in the next cycle. The stimulus for R6 holds the pad high through reset, so the synchronizer's zero-to-one fill would look like activity if the warm-up state were missing.

// File: rtl/iopin_pkg.sv
package iopin_pkg;

    typedef enum logic [1:0] {
        DRV_AUTO       = 2'd0,
        DRV_OPEN_DRAIN = 2'd1,
        DRV_PUSH_ONLY  = 2'd2,
        DRV_RESERVED   = 2'd3
    } drv_mode_e;

    typedef enum logic [1:0] {
        PULL_OFF_A = 2'd0,
        PULL_DOWN  = 2'd1,
        PULL_OFF_B = 2'd2,
        PULL_UP    = 2'd3
    } pull_sel_e;

    typedef enum logic [1:0] {
        EVS_WARMUP  = 2'd0,
        EVS_QUIET   = 2'd1,
        EVS_LATCHED = 2'd2
    } evt_state_e;

    typedef struct packed {
        pull_sel_e pull;
        drv_mode_e mode;
    } pin_cfg_t;

    localparam int unsigned CFG_W     = $bits(pin_cfg_t);
    localparam int unsigned LEVEL_BIT = 0;
    localparam int unsigned FLAG_BIT  = 1;

endpackage

// File: rtl/iopin_sync.sv
module iopin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic level,
    output logic change
);
    logic [STAGES-1:0] pipe;
    logic              last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= pad_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], pad_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= pipe[STAGES-1];
    end

    assign level  = pipe[STAGES-1];
    assign change = pipe[STAGES-1] ^ last;
endmodule

// File: rtl/iopin_drive.sv
module iopin_drive
    import iopin_pkg::*;
(
    input  drv_mode_e mode,
    input  pull_sel_e pull,
    input  logic      periph_out,
    input  logic      periph_oe,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      pull_up_en,
    output logic      pull_dn_en
);
    always_comb begin
        pad_out = periph_out;
        pad_oe  = periph_oe;
        unique case (mode)
            DRV_AUTO, DRV_RESERVED: begin
                pad_out = periph_out;
                pad_oe  = periph_oe;
            end
            DRV_OPEN_DRAIN: begin
                pad_out = 1'b0;
                pad_oe  = periph_oe & ~periph_out;
            end
            DRV_PUSH_ONLY: begin
                pad_out = 1'b1;
                pad_oe  = periph_oe & periph_out;
            end
        endcase
    end

    always_comb begin
        pull_up_en = 1'b0;
        pull_dn_en = 1'b0;
        unique case (pull)
            PULL_OFF_A, PULL_OFF_B: ;
            PULL_DOWN:              pull_dn_en = 1'b1;
            PULL_UP:                pull_up_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/iopin_regs.sv
module iopin_regs
    import iopin_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter int unsigned       DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter int unsigned       STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              level,
    input  logic              change,
    output pin_cfg_t          cfg,
    output logic              evt_flag
);
    localparam int unsigned       CNT_W    = $clog2(STAGES + 1) + 1;
    localparam logic [CNT_W-1:0]  WARM_END = CNT_W'(STAGES);
    localparam logic [ADDR_W-1:0] CFG_ADDR = BASE + ADDR_W'(1);

    logic       hit_stat, hit_cfg, clr_req;
    logic [CNT_W-1:0] warm_cnt;
    evt_state_e state_q, state_d;

    assign hit_stat = (bus_addr == BASE);
    assign hit_cfg  = (bus_addr == CFG_ADDR);
    assign clr_req  = bus_wr_en & hit_stat & ~bus_wdata[FLAG_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EVS_WARMUP;
        else        state_q <= state_d;
    end

    // Warm-up counter, active only in WARMUP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       warm_cnt <= '0;
        else if (state_q == EVS_WARMUP)   warm_cnt <= warm_cnt + CNT_W'(1);
    end

    // Next-state logic: a change outranks a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVS_WARMUP:  if (warm_cnt == WARM_END) state_d = EVS_QUIET;
            EVS_QUIET:   if (change)               state_d = EVS_LATCHED;
            EVS_LATCHED: if (clr_req && !change)   state_d = EVS_QUIET;
            default:                               state_d = EVS_WARMUP;
        endcase
    end

    // Output process
    always_comb begin
        evt_flag = (state_q == EVS_LATCHED);
    end

    // Setup register, write-only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cfg <= '0;
        else if (bus_wr_en && hit_cfg) cfg <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (hit_stat) begin
            bus_rdata[LEVEL_BIT] = level;
            bus_rdata[FLAG_BIT]  = evt_flag;
        end
    end
endmodule

// File: rtl/iopin_ctl.sv
module iopin_ctl
    import iopin_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          IS_ANALOG   = 1'b0,
    parameter int unsigned PIN_IDX     = 0,
    parameter int unsigned DIG_BASE    = 32'hE060,
    parameter int unsigned ANA_BASE    = 32'hE000,
    parameter int unsigned PIN_STRIDE  = 32'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              periph_out,
    input  logic              periph_oe,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pull_up_en,
    output logic              pull_dn_en
);
    localparam int unsigned       BASE_INT = (IS_ANALOG ? ANA_BASE : DIG_BASE) + PIN_STRIDE * PIN_IDX;
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_INT);

    logic     sync_level, sync_change, evt_flag;
    pin_cfg_t cfg_q;
    logic [1:0] cfg_mode;

    assign cfg_mode = cfg_q.mode;

    iopin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (sync_level),
        .change (sync_change)
    );

    iopin_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BASE   (BASE),
        .STAGES (SYNC_STAGES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (sync_level),
        .change    (sync_change),
        .cfg       (cfg_q),
        .evt_flag  (evt_flag)
    );

    iopin_drive u_drive (
        .mode       (cfg_q.mode),
        .pull       (cfg_q.pull),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en)
    );
endmodule

// File: rtl/iopin_ctl_chk.sv
module iopin_ctl_chk #(
    parameter int unsigned       ADDR_W = 16,
    parameter int unsigned       DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              periph_out,
    input logic              periph_oe,
    input logic              pad_out,
    input logic              pad_oe,
    input logic              pull_up_en,
    input logic              pull_dn_en,
    input logic [1:0]        mode,
    input logic              evt_flag,
    input logic              change
);
    logic clr_wr, cfg_wr;
    assign clr_wr = bus_wr_en && (bus_addr == BASE) && !bus_wdata[1];
    assign cfg_wr = bus_wr_en && (bus_addr == BASE + ADDR_W'(1));

    assert_auto_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || mode == 2'd3) |-> (pad_oe == periph_oe) && (!periph_oe || pad_out == periph_out));

    assert_od_no_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && pad_oe) |-> !pad_out);

    assert_od_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && (periph_out || !periph_oe)) |-> !pad_oe);

    assert_push_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && pad_oe) |-> pad_out);

    assert_push_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && (!periph_out || !periph_oe)) |-> !pad_oe);

    assert_pull_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_up_en && pull_dn_en));

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !clr_wr) |=> evt_flag);

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && clr_wr && !change) |=> !evt_flag);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && clr_wr && change) |=> evt_flag);

    assert_cfg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (mode == $past(bus_wdata[1:0])));
endmodule

bind iopin_ctl iopin_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BASE   (BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .mode       (cfg_mode),
    .evt_flag   (evt_flag),
    .change     (sync_change)
);

// File: tb/iopin_ctl_tb.sv
`timescale 1ns/1ps
module iopin_ctl_tb;
    localparam int unsigned AW   = 16;
    localparam int unsigned DW   = 8;
    localparam logic [AW-1:0] BASE  = 16'hE080;  // digital pin 2
    localparam logic [AW-1:0] OTHER = 16'hE060;  // digital pin 0

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = BASE;
    logic bus_wr_en = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic periph_out = 1'b0, periph_oe = 1'b0, pad_in = 1'b1;
    logic pad_out, pad_oe, pull_up_en, pull_dn_en;

    int total = 0, failed = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iopin_ctl #(.ADDR_W(AW), .DATA_W(DW), .PIN_IDX(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_out(periph_out),
        .periph_oe(periph_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = BASE;
        #1;
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = BASE;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        // pad held high through reset: no activity recorded (R6)
        repeat (6) @(posedge clk);
        read_at(BASE, d);
        check("R6", "flag after warm-up with pad high", d, 8'h01);
        check("R1", "pad_oe with mode 0 and periph_oe 0", {7'b0, pad_oe}, 8'h00);
        check("R1", "pull outputs", {6'b0, pull_up_en, pull_dn_en}, 8'h00);
    endtask

    task automatic t_level_timing;
        @(negedge clk) pad_in = 1'b0;
        @(posedge clk); #1;
        check("R2", "level after one edge", bus_rdata, 8'h01);
        @(posedge clk); #1;
        check("R2", "level after two edges", bus_rdata, 8'h00);
        @(posedge clk); #1;
        check("R3", "flag one edge after level", bus_rdata, 8'h02);
        bus_write(BASE, 8'h01);  // clears flag; bit0 write ignored
        check("R2", "bit0 write ignored", bus_rdata, 8'h00);
    endtask

    task automatic t_pulse;
        @(negedge clk) pad_in = 1'b1;
        @(negedge clk) pad_in = 1'b0;
        repeat (4) @(posedge clk); #1;
        check("R3", "short pulse caught", bus_rdata, 8'h02);
        repeat (10) @(posedge clk); #1;
        check("R4", "flag holds", bus_rdata, 8'h02);
        bus_write(BASE, 8'h02);
        check("R4", "write 1 keeps flag", bus_rdata, 8'h02);
        bus_write(BASE, 8'h00);
        check("R4", "write 0 clears flag", bus_rdata, 8'h00);
    endtask

    task automatic t_collide;
        @(negedge clk) pad_in = 1'b1;
        repeat (4) @(posedge clk); #1;
        check("R5", "flag latched before collision", bus_rdata, 8'h03);
        @(negedge clk) pad_in = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wdata = 8'h00; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        #1;
        check("R5", "set wins over clear", bus_rdata, 8'h02);
        bus_write(BASE, 8'h00);
        check("R5", "lone clear afterwards", bus_rdata, 8'h00);
    endtask

    task automatic drive_chk(input string req, input logic o, input logic e,
                             input logic exp_oe, input logic exp_out);
        @(negedge clk);
        periph_out = o; periph_oe = e;
        #1;
        check(req, "pad_oe", {7'b0, pad_oe}, {7'b0, exp_oe});
        if (exp_oe) check(req, "pad_out", {7'b0, pad_out}, {7'b0, exp_out});
    endtask

    task automatic t_modes;
        bus_write(BASE + 16'd1, 8'h00);
        drive_chk("R7", 1'b1, 1'b1, 1'b1, 1'b1);
        drive_chk("R7", 1'b0, 1'b1, 1'b1, 1'b0);
        drive_chk("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        bus_write(BASE + 16'd1, 8'h01);
        drive_chk("R8", 1'b0, 1'b1, 1'b1, 1'b0);
        drive_chk("R8", 1'b1, 1'b1, 1'b0, 1'b0);
        drive_chk("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        bus_write(BASE + 16'd1, 8'h02);
        drive_chk("R9", 1'b1, 1'b1, 1'b1, 1'b1);
        drive_chk("R9", 1'b0, 1'b1, 1'b0, 1'b0);
        drive_chk("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        bus_write(BASE + 16'd1, 8'h03);
        drive_chk("R7", 1'b0, 1'b1, 1'b1, 1'b0);
        drive_chk("R7", 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_pull;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] exp;
            bus_write(BASE + 16'd1, DW'(c << 2));
            exp = (c == 3) ? 2'b10 : (c == 1) ? 2'b01 : 2'b00;
            check("R10", $sformatf("pull code %0d {up,dn}", c),
                  {6'b0, pull_up_en, pull_dn_en}, {6'b0, exp});
        end
    endtask

    task automatic t_decode;
        logic [DW-1:0] d;
        bus_write(BASE + 16'd1, 8'hF0);  // mode 0, pull 0, upper bits ignored
        check("R11", "upper setup bits ignored", {6'b0, pull_up_en, pull_dn_en}, 8'h00);
        drive_chk("R11", 1'b1, 1'b1, 1'b1, 1'b1);
        bus_write(OTHER + 16'd1, 8'h0D);  // foreign pin: open-drain + pull-up
        drive_chk("R11", 1'b1, 1'b1, 1'b1, 1'b1);
        check("R11", "foreign write no pull", {6'b0, pull_up_en, pull_dn_en}, 8'h00);
        read_at(BASE + 16'd1, d);
        check("R11", "setup reads zero", d, 8'h00);
        @(negedge clk) pad_in = 1'b1;
        repeat (4) @(posedge clk);
        read_at(OTHER, d);
        check("R11", "foreign address reads zero", d, 8'h00);
        bus_write(OTHER, 8'h00);  // foreign clear must not touch flag
        check("R11", "foreign clear ignored", bus_rdata, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level_timing();
        t_pulse();
        t_collide();
        t_modes();
        t_pull();
        t_decode();
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule